// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a fast input clock, which stands in for an oscillator output, down to one short pulse per output cycle, for use by a phase comparator. The total ratio is P×N+A. A dual-modulus prescaler divides by P+1 or by P. A main counter counts N prescaler periods. A swallow counter keeps the prescaler at P+1 for the first A of those periods. Because the swallow counter steers the modulus, any integer ratio in the legal range can be reached, not only multiples of P.

The base ratio P is chosen by a mode pin: 8 (the prescaler divides by 8 or 9) or 64 (it divides by 64 or 65). Software-side logic presents N, A and the mode on plain control pins and pulses a load strobe. The block checks the request. A legal request is held in a staging register and takes effect only when the main counter reloads at the next cycle boundary. An illegal request is refused and raises an error flag. The block has no streaming data path: every pin is a plain control or status signal, and nothing exerts back-pressure.

Top module: `psd_divider`

## Requirements
- R1: In steady state, the distance between two consecutive rising edges of `div_pulse` is exactly P×N+A input clock cycles.
- R2: `cfg_mode_hi`=0 selects P=8, and `cfg_mode_hi`=1 selects P=64. The mode is staged and applied together with N and A.
- R3: With A=0, the ratio is exactly P×N, because no prescaler period is lengthened.
- R4: `div_pulse` is high for exactly one input clock cycle per output cycle.
- R5: A load with N below 3 sets `cfg_err` on the next clock edge. The running ratio is left unchanged.
- R6: A load with A greater than or equal to N sets `cfg_err` on the next clock edge. The running ratio is left unchanged.
- R7: A legal load clears `cfg_err` on the next clock edge. The output cycle in progress completes with the old ratio, and the next full cycle uses the new one.
- R8: While reset is asserted, `div_pulse` and `cfg_err` are 0. After reset the settings are N=3, A=0, P=8, so the first pulse appears on the 24th clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_vco | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | One-cycle strobe that submits cfg_n, cfg_a and cfg_mode_hi |
| cfg_n | input | 11 | Main counter ratio N (legal range 3 to 2047) |
| cfg_a | input | 7 | Swallow count A (0 to 127, must be below N) |
| cfg_mode_hi | input | 1 | 0: P=8, 1: P=64 |
| div_pulse | output | 1 | One-cycle pulse at the end of each output cycle |
| cfg_err | output | 1 | High after a refused load, low after an accepted load |

## Verification
The main function is tried under several input patterns. The first is a dense sweep of every legal A for each N from 3 to 12 with P=8. Errors of one prescaler period in the swallow phase show up there as off-by-one or off-by-P differences. Pairs with A=0 and A=N−1 separate a swallow counter that never acts from one that acts for too long. Settings with P=64, including A=127 and N=2047, show that the modulus selection and the wide counters are correct. Each load is followed by measuring both the partial old cycle and the first new cycle, which shows that updates wait for the boundary. Refused loads are then followed by two intervals that must keep the old ratio.

// File: rtl/psd_pkg.sv
package psd_pkg;
  parameter int unsigned N_W   = 11;
  parameter int unsigned A_W   = 7;
  parameter int unsigned MIN_N = 3;

  typedef struct packed {
    logic           hi;
    logic [N_W-1:0] n;
    logic [A_W-1:0] a;
  } psd_cfg_t;
endpackage

// File: rtl/psd_cfg_stage.sv
module psd_cfg_stage
  import psd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load_i,
  input  psd_cfg_t req_i,
  output psd_cfg_t stg_o,
  output logic     err_o
);
  psd_cfg_t stg_q;
  logic     req_ok;

  // legal: N not below the minimum and A strictly under N
  always_comb begin
    req_ok = (req_i.n >= N_W'(MIN_N)) && (N_W'(req_i.a) < req_i.n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q.hi <= 1'b0;
      stg_q.n  <= N_W'(MIN_N);
      stg_q.a  <= '0;
      err_o    <= 1'b0;
    end else if (load_i) begin
      if (req_ok) begin
        stg_q <= req_i;
        err_o <= 1'b0;
      end else begin
        err_o <= 1'b1;
      end
    end
  end

  assign stg_o = stg_q;

  p_staged_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stg_q.n >= N_W'(MIN_N)) && (N_W'(stg_q.a) < stg_q.n));
  p_refused_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !req_ok) |=> ($stable(stg_q) && err_o));
  p_accept_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && req_ok) |=> !err_o);
endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
  parameter int unsigned P_LO = 8,
  parameter int unsigned P_HI = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reload_hi_i,
  input  logic reload_ext_i,
  output logic tc_o
);
  localparam int unsigned PC_W = $clog2(P_HI + 1);

  logic [PC_W-1:0] pcnt_q;
  logic [PC_W-1:0] base;
  logic [PC_W-1:0] reload_val;

  // counts modulus-1 down to 0; modulus is P or P+1
  always_comb begin
    base       = reload_hi_i ? PC_W'(P_HI) : PC_W'(P_LO);
    reload_val = reload_ext_i ? base : base - 1'b1;
  end

  assign tc_o = (pcnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pcnt_q <= PC_W'(P_LO - 1);
    else if (tc_o) pcnt_q <= reload_val;
    else           pcnt_q <= pcnt_q - 1'b1;
  end

  p_pcnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q <= PC_W'(P_HI));
  p_steps_down_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pcnt_q != '0) |=> (pcnt_q == PC_W'($past(pcnt_q) - 1'b1)));
endmodule

// File: rtl/psd_swallow_ctrl.sv
module psd_swallow_ctrl
  import psd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tc_i,
  input  psd_cfg_t stg_i,
  output logic     end_o,
  output logic     next_hi_o,
  output logic     next_ext_o
);
  logic [N_W-1:0] ncnt_q, ncnt_d;
  logic [A_W-1:0] scnt_q, scnt_d;
  logic           hi_q, hi_d;
  logic           last;

  // ncnt: prescaler periods left including current
  // scnt: lengthened periods left including current
  assign last  = (ncnt_q == N_W'(1));
  assign end_o = tc_i && last;

  always_comb begin
    ncnt_d = ncnt_q;
    scnt_d = scnt_q;
    hi_d   = hi_q;
    if (tc_i) begin
      if (last) begin
        ncnt_d = stg_i.n;
        scnt_d = stg_i.a;
        hi_d   = stg_i.hi;
      end else begin
        ncnt_d = ncnt_q - 1'b1;
        if (scnt_q != '0) scnt_d = scnt_q - 1'b1;
      end
    end
  end

  assign next_hi_o  = hi_d;
  assign next_ext_o = (scnt_d != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ncnt_q <= N_W'(MIN_N);
      scnt_q <= '0;
      hi_q   <= 1'b0;
    end else begin
      ncnt_q <= ncnt_d;
      scnt_q <= scnt_d;
      hi_q   <= hi_d;
    end
  end

  p_swallow_below_main_r6: assert property (@(posedge clk) disable iff (!rst_n)
    N_W'(scnt_q) < ncnt_q);
  p_main_nonzero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ncnt_q != '0);
  p_mode_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !end_o |=> $stable(hi_q));
endmodule

// File: rtl/psd_divider.sv
module psd_divider #(
  parameter int unsigned P_LO = 8,
  parameter int unsigned P_HI = 64
) (
  input  logic        clk_vco,
  input  logic        rst_n,
  input  logic        cfg_load,
  input  logic [10:0] cfg_n,
  input  logic [6:0]  cfg_a,
  input  logic        cfg_mode_hi,
  output logic        div_pulse,
  output logic        cfg_err
);
  import psd_pkg::*;

  psd_cfg_t req, stg;
  logic     pre_tc, cyc_end, nxt_hi, nxt_ext;

  assign req.hi = cfg_mode_hi;
  assign req.n  = cfg_n;
  assign req.a  = cfg_a;

  psd_cfg_stage u_stage (
    .clk    (clk_vco),
    .rst_n  (rst_n),
    .load_i (cfg_load),
    .req_i  (req),
    .stg_o  (stg),
    .err_o  (cfg_err)
  );

  psd_prescaler #(.P_LO(P_LO), .P_HI(P_HI)) u_pre (
    .clk          (clk_vco),
    .rst_n        (rst_n),
    .reload_hi_i  (nxt_hi),
    .reload_ext_i (nxt_ext),
    .tc_o         (pre_tc)
  );

  psd_swallow_ctrl u_ctrl (
    .clk        (clk_vco),
    .rst_n      (rst_n),
    .tc_i       (pre_tc),
    .stg_i      (stg),
    .end_o      (cyc_end),
    .next_hi_o  (nxt_hi),
    .next_ext_o (nxt_ext)
  );

  always_ff @(posedge clk_vco or negedge rst_n) begin
    if (!rst_n) div_pulse <= 1'b0;
    else        div_pulse <= cyc_end;
  end

  p_pulse_single_r4: assert property (@(posedge clk_vco) disable iff (!rst_n)
    div_pulse |=> !div_pulse);
  p_pulse_from_end_r1: assert property (@(posedge clk_vco) disable iff (!rst_n)
    cyc_end |=> div_pulse);
endmodule

// File: tb/psd_divider_tb_top.sv
`timescale 1ns/1ps
module psd_divider_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [10:0] cfg_n = '0;
  logic [6:0]  cfg_a = '0;
  logic        cfg_mode_hi = 1'b0;
  logic        div_pulse, cfg_err;
  int checks = 0;
  int fails = 0;
  int cur_ratio = 0;

  always #2 clk = ~clk;

  psd_divider dut_i (
    .clk_vco(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_n(cfg_n),
    .cfg_a(cfg_a), .cfg_mode_hi(cfg_mode_hi), .div_pulse(div_pulse), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse(output int n);
    n = 0;
    do begin
      @(posedge clk); #1;
      n++;
    end while (!div_pulse && n < 20000);
  endtask

  // sync to a pulse, check width, submit, then measure old tail and new cycle
  task automatic submit(input int n, input int a, input bit hi, input bit legal, input string req);
    int x, y, expv;
    wait_pulse(x);
    @(posedge clk); #1;
    chk(!div_pulse, "R4", div_pulse, 0);
    cfg_n = 11'(n); cfg_a = 7'(a); cfg_mode_hi = hi; cfg_load = 1'b1;
    @(posedge clk); #1;
    cfg_load = 1'b0;
    chk(cfg_err == !legal, legal ? "R7" : req, cfg_err, !legal);
    wait_pulse(x);
    chk(x + 2 == cur_ratio, "R7", x + 2, cur_ratio);
    expv = legal ? ((hi ? 64 : 8) * n + a) : cur_ratio;
    wait_pulse(y);
    chk(y == expv, req, y, expv);
    cur_ratio = expv;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int x;
    repeat (3) @(posedge clk); #1;
    chk(div_pulse == 1'b0, "R8", div_pulse, 0);
    chk(cfg_err == 1'b0, "R8", cfg_err, 0);
    rst_n = 1'b1;
    wait_pulse(x);
    chk(x == 24, "R8", x, 24);
    cur_ratio = 24;

    // dense sweep at P=8
    for (int n = 3; n <= 12; n++)
      for (int a = 0; a < n; a++)
        submit(n, a, 1'b0, 1'b1, (a == 0) ? "R3" : "R1");

    // P=64 settings and wide values
    submit(3, 0, 1'b1, 1'b1, "R3");
    submit(3, 2, 1'b1, 1'b1, "R2");
    submit(5, 4, 1'b1, 1'b1, "R2");
    submit(20, 19, 1'b1, 1'b1, "R2");
    submit(130, 127, 1'b1, 1'b1, "R2");
    submit(200, 127, 1'b0, 1'b1, "R1");
    submit(2047, 0, 1'b0, 1'b1, "R3");
    submit(7, 3, 1'b0, 1'b1, "R1");

    // refused loads
    submit(2, 0, 1'b1, 1'b0, "R5");
    submit(0, 0, 1'b0, 1'b0, "R5");
    submit(5, 5, 1'b1, 1'b0, "R6");
    submit(5, 9, 1'b0, 1'b0, "R6");
    submit(4, 3, 1'b1, 1'b1, "R7");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule